// File: doc/BRIEF.md
# Runt-Free Gated Clock Fanout

This block fans one clock out to six output pairs and one feedback pair. The clock source is either the reference input directly, in bypass, or a clock from an external PLL. Each of the six pairs can be switched on or off by a bit in one of two 8-bit configuration bytes. A pair that is switched off floats: both its true and complement lines are high impedance. The tri-state condition of each line is shown by an output-enable signal. The feedback pair always runs and has no bit that can switch it off.

Enable changes are taken in only while the selected clock is low. As a result, a pair always starts and stops on a whole pulse.

A separate sample clock measures the reference frequency. If the reference runs too slowly, or stops, every pair floats, including the feedback pair. The outputs are driven again only after two measurement windows in a row have shown a healthy rate.

Top module: `clk_fanout_gate`

## Requirements
- R1: The enable bits map to outputs as follows. Output 0 is `en_lo[7]`, output 1 is `en_lo[6]`, output 2 is `en_lo[3]`, output 3 is `en_hi[6]`, output 4 is `en_lo[0]` and output 5 is `en_lo[2]`. A 1 makes `out_oe[i]` high. A 0 makes it low, which means both lines of that pair are high impedance.
- R2: `en_lo` bits 5, 4 and 1 have no effect on any output. Neither do all `en_hi` bits except bit 6.
- R3: No configuration bit can float the feedback pair. While the frequency check is satisfied, `fb_oe` is 1, `fb_t` follows the selected clock and `fb_c` is its inverse.
- R4: An output pair never emits a high pulse shorter than a half period of the selected clock. A new enable value takes effect only at a falling edge of that clock.
- R5: A window is `WIN_CYC` sample-clock cycles long; the defaults are 250 cycles and 20 edges. If fewer than `MIN_EDGES` reference rising edges are seen in one window, `fb_oe` and all `out_oe` bits go to 0 in the following cycle. With the defaults and a 250 MHz sample clock, this means a reference below 20 MHz. A stopped reference has the same effect.
- R6: After reset all outputs are high impedance. They are driven again only after two consecutive windows have each reached `MIN_EDGES`. A single good window never releases them.
- R7: While a pair is driven, `out_t[i]` equals the selected clock.
- R8: With `pll_on` = 0 the selected clock is `ref_clk`, which bypasses the PLL. With `pll_on` = 1 it is `pll_clk`.
- R9: While a pair is driven, `out_c[i]` is the inverse of `out_t[i]`. While it floats, `out_c[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp_clk | input | 1 | Fixed-rate sample clock used to measure the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock (true line) |
| pll_clk | input | 1 | Clock from the external PLL |
| pll_on | input | 1 | 1 selects `pll_clk`, 0 bypasses to `ref_clk` |
| en_lo | input | 8 | First enable byte |
| en_hi | input | 8 | Second enable byte |
| out_t | output | 6 | True lines of the output pairs |
| out_c | output | 6 | Complement lines of the output pairs |
| out_oe | output | 6 | 1 = pair driven, 0 = pair high impedance |
| fb_t | output | 1 | Feedback true line |
| fb_c | output | 1 | Feedback complement line |
| fb_oe | output | 1 | 1 = feedback pair driven |

## Verification
The assertions rely on three properties of the inputs:
- The sample clock is faster than both clock sources.
- Each half period of the selected clock is longer than one sample period.
- The enable bytes and `pll_on` never change exactly on a clock edge.

The bench meets these conditions as follows. It keeps every stimulus edge half a nanosecond away from the integer-nanosecond clock edges. It runs the reference at half periods of 5 ns or more and the PLL clock at 6 ns, against a 4 ns sample clock. It also suspends its pulse-width monitor while `pll_on` is changed, because that switch is a static strap.

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate #(
  parameter int WIN_CYC   = 250,
  parameter int MIN_EDGES = 20
) (
  input  logic       smp_clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic       pll_clk,
  input  logic       pll_on,
  input  logic [7:0] en_lo,
  input  logic [7:0] en_hi,
  output logic [5:0] out_t,
  output logic [5:0] out_c,
  output logic [5:0] out_oe,
  output logic       fb_t,
  output logic       fb_c,
  output logic       fb_oe
);

  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int EW = $clog2(MIN_EDGES + 1);

  function automatic logic [5:0] pick_enables(input logic [15:0] w);
    return {w[2], w[0], w[14], w[3], w[6], w[7]};
  endfunction

  logic          src_clk;
  logic [5:0]    en_req, en_q;
  logic          ref_tog;
  logic [2:0]    tog_s;
  logic          edge_hit;
  logic [WW-1:0] win_cnt;
  logic          win_done;
  logic [EW-1:0] edge_cnt, cnt_next;
  logic          win_good, prev_good, slow;

  assign src_clk = pll_on ? pll_clk : ref_clk;
  assign en_req  = pick_enables({en_hi, en_lo});

  always_ff @(negedge src_clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else        en_q <= en_req;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ref_tog <= 1'b0;
    else        ref_tog <= ~ref_tog;

  always_ff @(posedge smp_clk or negedge rst_n)
    if (!rst_n) tog_s <= '0;
    else        tog_s <= {tog_s[1:0], ref_tog};

  assign edge_hit = tog_s[2] ^ tog_s[1];
  assign win_done = (win_cnt == WW'(WIN_CYC - 1));
  assign cnt_next = (edge_hit && int'(edge_cnt) < MIN_EDGES) ? edge_cnt + 1'b1 : edge_cnt;
  assign win_good = (int'(cnt_next) >= MIN_EDGES);

  always_ff @(posedge smp_clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt   <= '0;
      edge_cnt  <= '0;
      prev_good <= 1'b0;
      slow      <= 1'b1;
    end else if (win_done) begin
      win_cnt   <= '0;
      edge_cnt  <= '0;
      prev_good <= win_good;
      slow      <= !(win_good && prev_good);
    end else begin
      win_cnt   <= win_cnt + 1'b1;
      edge_cnt  <= cnt_next;
    end

  assign out_t  = {6{src_clk}} & en_q;
  assign out_oe = en_q & {6{~slow}};
  assign out_c  = out_oe & ~out_t;
  assign fb_t   = src_clk;
  assign fb_c   = ~src_clk;
  assign fb_oe  = ~slow;

  // R1
  cfg_capture_chk: assert property (@(negedge src_clk) disable iff (!rst_n)
    1'b1 |=> (en_q == $past(pick_enables({en_hi, en_lo}))));

  // R4
  enable_low_phase_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
    !$stable(en_q) |-> !src_clk);

  // R5
  low_window_slow_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (win_done && !win_good) |=> (out_oe == '0 && !fb_oe));

  // R6
  release_at_window_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
    $rose(fb_oe) |-> $past(win_done));

endmodule

// File: tb/clk_fanout_gate_bench.sv
`timescale 1ns/100ps
module clk_fanout_gate_bench;
  logic smp_clk = 1'b0, ref_clk = 1'b0, pll_clk = 1'b0;
  logic rst_n, pll_on;
  logic [7:0] en_lo, en_hi;
  logic [5:0] out_t, out_c, out_oe;
  logic fb_t, fb_c, fb_oe;
  int ref_half = 5;
  bit ref_stop = 1'b0, mon_on = 1'b0, done = 1'b0;
  int checks = 0, fails = 0;
  int runts [6];
  realtime rise_t [6];

  clk_fanout_gate u_clk_fanout_gate (.smp_clk(smp_clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .pll_clk(pll_clk), .pll_on(pll_on), .en_lo(en_lo), .en_hi(en_hi), .out_t(out_t),
    .out_c(out_c), .out_oe(out_oe), .fb_t(fb_t), .fb_c(fb_c), .fb_oe(fb_oe));

  always #2 smp_clk = ~smp_clk;
  always #6 pll_clk = ~pll_clk;
  always begin
    if (ref_stop) begin ref_clk = 1'b0; #1; end
    else begin ref_clk = 1'b1; #(ref_half); ref_clk = 1'b0; #(ref_half); end
  end

  function automatic logic [5:0] exp_map(input logic [7:0] lo, input logic [7:0] hi);
    return {lo[2], lo[0], hi[6], lo[3], lo[6], lo[7]};
  endfunction

  function automatic real cur_half();
    return pll_on ? 6.0 : real'(ref_half);
  endfunction

  for (genvar g = 0; g < 6; g++) begin : g_mon
    initial runts[g] = 0;
    always @(posedge out_t[g]) rise_t[g] = $realtime;
    always @(negedge out_t[g])
      if (mon_on && rst_n && ($realtime - rise_t[g] < cur_half() - 0.05)) runts[g]++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sample_outputs(input string req);
    logic [5:0] e, et;
    logic s;
    e  = exp_map(en_lo, en_hi);
    s  = pll_on ? pll_clk : ref_clk;
    et = e & {6{s}};
    chk(out_oe == e, "R1", out_oe, e);
    chk(out_t == et, req, out_t, et);
    chk(out_c == (e & ~et), "R9", out_c, e & ~et);
    chk(fb_oe && fb_t == s && fb_c == ~s, "R3", {fb_oe, fb_t, fb_c}, {1'b1, s, ~s});
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] keep;
    int total;
    void'($urandom(32'd4242));
    rst_n = 1'b0; pll_on = 1'b0; en_lo = 8'hFF; en_hi = 8'hFF;
    #10.5;
    chk(out_oe == 6'd0 && !fb_oe, "R6", {out_oe, fb_oe}, 0);
    rst_n = 1'b1;
    #100;
    chk(out_oe == 6'd0 && !fb_oe, "R6", {out_oe, fb_oe}, 0);
    mon_on = 1'b1;
    #2500;
    sample_outputs("R7");
    for (int i = 0; i < 24; i++) begin
      en_lo = 8'($urandom); en_hi = 8'($urandom);
      #(40 + $urandom % 20);
      for (int k = 0; k < 4; k++) begin
        #(1 + $urandom % 7);
        sample_outputs("R7");
      end
    end
    for (int i = 0; i < 6; i++) begin
      en_lo = 8'h00; en_hi = 8'h00;
      case (i)
        0: en_lo = 8'h80; 1: en_lo = 8'h40; 2: en_lo = 8'h08;
        3: en_hi = 8'h40; 4: en_lo = 8'h01; default: en_lo = 8'h04;
      endcase
      #40;
      chk(out_oe == 6'(1 << i), "R1", out_oe, 1 << i);
    end
    en_lo = 8'hCD; en_hi = 8'h40;
    #40;
    keep = out_oe;
    en_lo = en_lo ^ 8'h32; en_hi = en_hi ^ 8'hBF;
    #40;
    chk(out_oe == keep, "R2", out_oe, keep);
    sample_outputs("R2");
    en_lo = 8'h00; en_hi = 8'h00;
    #40;
    chk(out_oe == 6'd0 && fb_oe, "R3", {out_oe, fb_oe}, 1);
    en_lo = 8'hFF; en_hi = 8'hFF;
    mon_on = 1'b0; pll_on = 1'b1; #40; mon_on = 1'b1;
    for (int k = 0; k < 12; k++) begin
      #(1 + $urandom % 9);
      sample_outputs("R8");
    end
    mon_on = 1'b0; pll_on = 1'b0; #40; mon_on = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #(1 + $urandom % 9);
      sample_outputs("R8");
    end
    for (int i = 0; i < 40; i++) begin
      en_lo = 8'($urandom); en_hi = 8'($urandom);
      #(1 + $urandom % 13);
    end
    #40;
    total = 0;
    for (int g = 0; g < 6; g++) total += runts[g];
    chk(total == 0, "R4", total, 0);
    mon_on = 1'b0;
    en_lo = 8'hFF; en_hi = 8'hFF;
    ref_half = 30;
    #2600;
    chk(out_oe == 6'd0 && !fb_oe, "R5", {out_oe, fb_oe}, 0);
    ref_stop = 1'b1;
    #2600;
    chk(out_oe == 6'd0 && !fb_oe, "R5", {out_oe, fb_oe}, 0);
    ref_half = 20; ref_stop = 1'b0;
    #900;
    chk(out_oe == 6'd0 && !fb_oe, "R6", {out_oe, fb_oe}, 0);
    #1700;
    chk(out_oe == 6'h3F && fb_oe, "R6", {out_oe, fb_oe}, 8'h7F);
    sample_outputs("R7");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule